// File: doc/BRIEF.md
# Interruptible SDRAM Column Burst Sequencer

This block turns an accepted read or write column command into a run of per-clock data beats. For each beat it drives a column address, a beat-valid flag and a read/write flag. How many beats a command yields comes from a small programmable length field. Beats follow sequential order and wrap inside the aligned block that the burst length defines. In full-page mode that block is the whole column space.

A fresh command may arrive on any clock, including in the middle of a burst. It drops whatever beats of the old burst remain. On the very next cycle the sequence restarts at the new column, and beat-valid does not fall between the two bursts. The done pulse marks only a burst that ran to its last beat. The length field can be rewritten only while the sequencer is idle. Read-data latency alignment and the memory array itself sit outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, beat_valid and burst_done are low and the burst length is 1 (length code 000).
- R2: A command sampled with cmd_valid high at a rising edge gives, in the next cycle, beat_valid high, col_addr equal to cmd_col and beat_write equal to cmd_write.
- R3: Without interruption, a burst issues exactly one beat per clock on consecutive cycles. The beat count follows the length code: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page (2^COL_W), and any other code gives 1.
- R4: Beat k of a burst of length L starting at column S has the address floor(S/L)*L + ((S+k) mod L). The order is sequential and wraps inside the aligned L-column block.
- R5: A command accepted while a burst still has beats left discards those beats. The next cycle carries the new command's first beat, and beat_valid stays high throughout.
- R6: burst_done is high for one cycle, in the cycle right after the last beat of a burst that issued all its beats. An interrupted burst never raises burst_done.
- R7: A length write (mode_we) takes effect at a rising edge only when beat_valid and cmd_valid are both low. Otherwise it is ignored and the stored length is unchanged.
- R8: beat_write stays constant for every beat of one burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Length-field write strobe |
| mode_bl | input | 3 | Length code to store |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Starting column of the command |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | Current cycle carries a beat |
| beat_write | output | 1 | Current beat belongs to a write |
| burst_done | output | 1 | Previous cycle was the final beat of an uninterrupted burst |

## Verification
The bench builds the sequencer with COL_W set to 5. This keeps a full-page burst down to 32 beats, so the wrap of the whole column space is reached several times within a short run. Directed cases start bursts at unaligned columns for every length code, including a reserved one. They interrupt bursts both mid-way and exactly on the last beat, and they attempt length writes during bursts and in the same cycle as a command. A random phase then mixes commands and length writes, and a behavioural model checks every output on every cycle.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [2:0]       mode_bl,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_write,
  output logic             burst_done
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic [2:0]       bl_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] off_q;
  logic [COL_W-1:0] mask;
  logic             last_beat;

  always_comb begin
    case (bl_q)
      3'b001:  mask = COL_W'(1);
      3'b010:  mask = COL_W'(3);
      3'b011:  mask = COL_W'(7);
      3'b111:  mask = PAGE_MASK;
      default: mask = '0;
    endcase
  end

  assign last_beat = beat_valid && (off_q == mask);
  assign col_addr  = (start_q & ~mask) | ((start_q + off_q) & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_q       <= 3'b000;
      start_q    <= '0;
      off_q      <= '0;
      beat_valid <= 1'b0;
      beat_write <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      burst_done <= last_beat;
      if (cmd_valid) begin
        start_q    <= cmd_col;
        off_q      <= '0;
        beat_valid <= 1'b1;
        beat_write <= cmd_write;
      end else if (beat_valid) begin
        if (last_beat) beat_valid <= 1'b0;
        else           off_q      <= off_q + 1'b1;
      end
      if (mode_we && !beat_valid && !cmd_valid) bl_q <= mode_bl;
    end
  end

endmodule

module sdram_burst_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [COL_W-1:0] cmd_col,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_valid,
  input logic             beat_write,
  input logic             burst_done,
  input logic [2:0]       bl_q
);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid && col_addr == $past(cmd_col) && beat_write == $past(cmd_write));

  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && cmd_valid) |=> beat_valid);

  p_done_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_valid) |-> burst_done);

  p_done_follows_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(beat_valid));

  p_len_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid || cmd_valid) |=> $stable(bl_q));

  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !cmd_valid) |=> (!beat_valid || $stable(beat_write)));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb_top;
  localparam int COL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [2:0] mode_bl = 3'b000;
  logic cmd_valid = 1'b0;
  logic cmd_write = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [COL_W-1:0] col_addr;
  logic beat_valid, beat_write, burst_done;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_bl(mode_bl),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .col_addr(col_addr), .beat_valid(beat_valid), .beat_write(beat_write),
    .burst_done(burst_done));

  // behavioural reference
  int  m_len_cfg = 1;
  int  m_len = 1, m_start = 0, m_k = 0;
  bit  m_active = 0, m_wr = 0, m_done = 0;

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 1 << COL_W;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_len_cfg = 1; m_active = 0; m_done = 0; m_wr = 0; m_k = 0; m_start = 0; m_len = 1;
    end else begin
      bit was_active;
      was_active = m_active;
      m_done = m_active && (m_k == m_len - 1);
      if (cmd_valid) begin
        m_active = 1; m_start = int'(cmd_col); m_k = 0; m_wr = cmd_write; m_len = m_len_cfg;
      end else if (m_active) begin
        if (m_k == m_len - 1) m_active = 0;
        else m_k++;
      end
      if (mode_we && !was_active && !cmd_valid) m_len_cfg = code_len(mode_bl);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(beat_valid == m_active, "R3 beat_valid", int'(beat_valid), int'(m_active));
      check(burst_done == m_done, "R6 burst_done", int'(burst_done), int'(m_done));
      if (m_active) begin
        int ea;
        ea = (m_start / m_len) * m_len + ((m_start + m_k) % m_len);
        check(int'(col_addr) == ea, "R4 col_addr", int'(col_addr), ea);
        check(beat_write == m_wr, "R8 beat_write", int'(beat_write), int'(m_wr));
      end
    end
  end

  task automatic drive(input bit v, input bit w, input int c, input bit mwe, input logic [2:0] bl);
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_col = COL_W'(c); mode_we = mwe; mode_bl = bl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 3'b000);
  endtask

  task automatic set_len(input logic [2:0] bl);
    drive(0, 0, 0, 1, bl);
    idle(1);
  endtask

  task automatic cmd_chk(input bit w, input int c, input string req);
    drive(1, w, c, 0, 3'b000);
    drive(0, 0, 0, 0, 3'b000);
    check(beat_valid && int'(col_addr) == c, req, int'(col_addr), c);
  endtask

  task automatic count_burst(input int exp, input string req);
    int n;
    n = 0;
    drive(1, 0, 3, 0, 3'b000);
    drive(0, 0, 0, 0, 3'b000);
    while (beat_valid && n < 100) begin n++; drive(0, 0, 0, 0, 3'b000); end
    check(n == exp, req, n, exp);
  endtask

  task automatic report;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R3 actual=%0d expected=%0d", cycles, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!beat_valid && !burst_done, "R1 outputs idle in reset", int'(beat_valid), 0);
    rst_n = 1'b1;
    idle(1);
    count_burst(1, "R1 default length 1");
    idle(2);
    // R2/R4: length 4 from an unaligned column
    set_len(3'b010);
    cmd_chk(0, 6, "R2 first beat address");
    idle(6);
    // R3: every code incl. reserved
    set_len(3'b001); count_burst(2, "R3 length code 001");
    set_len(3'b011); count_burst(8, "R3 length code 011");
    set_len(3'b101); count_burst(1, "R3 reserved code 101");
    set_len(3'b111); count_burst(32, "R3 full page");
    idle(2);
    // R5: interrupt mid-burst, plus ignored length write (R7)
    set_len(3'b011);
    drive(1, 1, 13, 0, 3'b000);
    drive(0, 0, 0, 1, 3'b001);
    drive(0, 0, 0, 0, 3'b000);
    cmd_chk(0, 30, "R5 interrupt new address");
    idle(10);
    count_burst(8, "R7 write during burst ignored");
    // R7: write in the same cycle as a command is ignored
    drive(1, 0, 9, 1, 3'b000);
    idle(10);
    count_burst(8, "R7 write with command ignored");
    // R6: interrupt exactly on the last beat
    set_len(3'b001);
    drive(1, 0, 4, 0, 3'b000);
    drive(0, 0, 0, 0, 3'b000);
    drive(1, 1, 17, 0, 3'b000);
    drive(0, 0, 0, 0, 3'b000);
    check(burst_done == 1'b1, "R6 done on completed burst", int'(burst_done), 1);
    idle(4);
    // R5: commands on every cycle at length 1
    set_len(3'b000);
    for (int i = 0; i < 6; i++) drive(1, i[0], i * 5, 0, 3'b000);
    idle(3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 20, $urandom_range(0, 1) == 1, $urandom_range(0, 31),
            r >= 90, 3'($urandom_range(0, 7)));
    end
    idle(40);
    report();
  end
endmodule